// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Reader

This block is the read side of a configuration store that streams a preloaded bitstream into a downstream device. The array is filled through a simple write port. A position counter then walks the array, one step per qualifying rising clock edge. The block shows the word at the current position on its data outputs, either as a single bit on lane 0 or as a full byte on all eight lanes. The receiver captures each word on the rising edge that follows the one that moved the counter.

Two inputs gate the reader. The first is an active-low select. The second is a combined input that enables the outputs and, when low, resets the counter. When the last word has been passed, the data outputs let go and a chain-select output becomes active. That output wakes the next store in a chain that shares clock and data lines. Its polarity is a build-time parameter.

Top module: `cfg_stream_reader`

## Requirements
- R1: On a rising clock edge with `sel_n` low, `en_rst_n` high and the end not yet passed, the read position advances by exactly one word.
- R2: While `en_rst_n` is low, `dout_oe` is 8'h00 in the same cycle, and at the next rising edge the read position returns to word 0 and the end flag clears.
- R3: While `sel_n` is high, `dout_oe` is 8'h00 and the read position holds across clock edges.
- R4: With `par_mode` = 0 (serial), `dout_oe` is 8'h01 and `dout[7:1]` is 0. `dout[0]` carries bit (7 - p mod 8) of byte p/8 at position p, so each byte goes out most-significant bit first.
- R5: With `par_mode` = 1 (parallel), `dout_oe` is 8'hFF and `dout` equals the byte at the current position.
- R6: The last position is 8*DEPTH-1 in serial mode and DEPTH-1 in parallel mode. A qualifying edge at the last position sets the end flag. After that the position stops and `dout_oe` is 8'h00.
- R7: Once the end flag is set, `chain_sel` is active exactly while `sel_n` is low and `en_rst_n` is high, and follows `sel_n` combinationally.
- R8: When `en_rst_n` goes low, `chain_sel` goes inactive at once. It stays inactive after release until the array has been read to its end again.
- R9: With parameter CHAIN_ACT_HIGH = 1, `chain_sel` is high when active and low when inactive. With 0 the levels are the other way round.
- R10: A rising edge with `wr_en` high stores `wr_data` at byte address `wr_addr`, and later reads of that address return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and write clock |
| sel_n | input | 1 | Active-low select; high puts the reader in standby |
| en_rst_n | input | 1 | High enables outputs; low resets the read position |
| par_mode | input | 1 | 0 = one bit per word, 1 = one byte per word |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | $clog2(DEPTH) | Preload byte address |
| wr_data | input | 8 | Preload byte |
| dout | output | 8 | Data value lanes |
| dout_oe | output | 8 | Per-lane drive enable (0 = high impedance) |
| chain_sel | output | 1 | Select for the next store in a chain |

## Verification
The data outputs, `dout_oe` and `chain_sel` are combinational from the position register and the two gate inputs. A change of `sel_n` or `en_rst_n` therefore shows on them in the same cycle. A counter step or a reset shows one edge later. The bench drives every input 1 ns after a rising edge and samples 1 ns after that. A gate change is checked before the next edge, and an advance is checked only after the edge that causes it, so each word is compared in exactly the cycle the receiver would capture it.

// File: rtl/cfg_stream_pkg.sv
// Package: shared widths and helpers for the configuration bitstream reader.
// Assumes: one storage word is always one byte.
package cfg_stream_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_SEL_W = 3;

    // Last readable position for an array of depth bytes in the given mode.
    function automatic int last_pos(input int depth, input bit parallel);
        return parallel ? depth - 1 : depth * BYTE_W - 1;
    endfunction
endpackage

// File: rtl/cfg_mem_array.sv
// Module: byte-wide storage array with a synchronous preload port and an
// asynchronous read port.
// Assumes: preload and reading are not mixed on the same address in one cycle;
// the array has no reset, so its contents are undefined until written.
module cfg_mem_array
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [BYTE_W-1:0] store_q [DEPTH];

    // Preload: store one byte per strobed edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    // Read: present the addressed byte without a pipeline stage.
    always_comb begin
        rd_byte = store_q[rd_addr];
    end
endmodule

// File: rtl/cfg_pos_counter.sv
// Module: read position counter with an end-of-array flag.
// Assumes: last_pos is stable while en_rst_n is high; the enable/reset input is
// sampled synchronously and is the only reset of this state.
module cfg_pos_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             en_rst_n,
    input  logic             sel_n,
    input  logic [CNT_W-1:0] last_pos,
    output logic [CNT_W-1:0] pos_q,
    output logic             end_q
);
    logic step;

    // Qualify an advance: selected, enabled, end not yet passed.
    always_comb begin
        step = !sel_n && !end_q;
    end

    // Position and end flag: reset while disabled, freeze once past the end.
    always_ff @(posedge clk) begin
        if (!en_rst_n) begin
            pos_q <= '0;
            end_q <= 1'b0;
        end else if (step) begin
            if (pos_q == last_pos) begin
                end_q <= 1'b1;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_out_stage.sv
// Module: maps the read position to a byte address, picks the serial bit or the
// full byte, gates the lane enables and forms the chain select.
// Assumes: DEPTH >= 2 so the byte address has at least one bit.
module cfg_out_stage
    import cfg_stream_pkg::*;
#(
    parameter int  DEPTH          = 64,
    parameter bit  CHAIN_ACT_HIGH = 1'b0,
    localparam int AW             = $clog2(DEPTH),
    localparam int CNT_W          = $clog2(DEPTH * BYTE_W)
) (
    input  logic              par_mode,
    input  logic              sel_n,
    input  logic              en_rst_n,
    input  logic [CNT_W-1:0]  pos_q,
    input  logic              end_q,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] dout,
    output logic [BYTE_W-1:0] dout_oe,
    output logic              chain_sel
);
    logic                 live;
    logic [BIT_SEL_W-1:0] bit_idx;
    logic                 chain_act;

    // Address: byte position in parallel mode, position / 8 in serial mode.
    always_comb begin
        rd_addr = par_mode ? pos_q[AW-1:0] : pos_q[CNT_W-1:BIT_SEL_W];
    end

    // Serial bit choice: most-significant bit of each byte first.
    always_comb begin
        bit_idx = BIT_SEL_W'(BYTE_W - 1) - pos_q[BIT_SEL_W-1:0];
    end

    // Lanes drive only while selected, enabled and not past the end.
    always_comb begin
        live = !sel_n && en_rst_n && !end_q;
    end

    // Data value and per-lane enables for the chosen mode.
    always_comb begin
        if (par_mode) begin
            dout    = rd_byte;
            dout_oe = {BYTE_W{live}};
        end else begin
            dout    = {{(BYTE_W-1){1'b0}}, rd_byte[bit_idx]};
            dout_oe = {{(BYTE_W-1){1'b0}}, live};
        end
    end

    // Chain select: active past the end while selected and enabled.
    always_comb begin
        chain_act = end_q && !sel_n && en_rst_n;
    end

    // Output polarity chosen at build time.
    generate
        if (CHAIN_ACT_HIGH) begin : g_pol_high
            assign chain_sel = chain_act;
        end else begin : g_pol_low
            assign chain_sel = !chain_act;
        end
    endgenerate
endmodule

// File: rtl/cfg_stream_reader.sv
// Module: top of the cascadable configuration bitstream reader.
// Assumes: par_mode changes only while en_rst_n is low; preload happens before a
// read pass starts.
module cfg_stream_reader
    import cfg_stream_pkg::*;
#(
    parameter int  DEPTH          = 64,
    parameter bit  CHAIN_ACT_HIGH = 1'b0,
    localparam int AW             = $clog2(DEPTH),
    localparam int CNT_W          = $clog2(DEPTH * BYTE_W)
) (
    input  logic              clk,
    input  logic              sel_n,
    input  logic              en_rst_n,
    input  logic              par_mode,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] dout,
    output logic [BYTE_W-1:0] dout_oe,
    output logic              chain_sel
);
    localparam logic [CNT_W-1:0] LAST_SER = CNT_W'(last_pos(DEPTH, 1'b0));
    localparam logic [CNT_W-1:0] LAST_PAR = CNT_W'(last_pos(DEPTH, 1'b1));

    logic [CNT_W-1:0]  last_sel;
    logic [CNT_W-1:0]  pos_q;
    logic              end_q;
    logic [AW-1:0]     rd_addr;
    logic [BYTE_W-1:0] rd_byte;

    // Last position for the current mode.
    always_comb begin
        last_sel = par_mode ? LAST_PAR : LAST_SER;
    end

    cfg_mem_array #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte)
    );

    cfg_pos_counter #(.CNT_W(CNT_W)) u_pos (
        .clk      (clk),
        .en_rst_n (en_rst_n),
        .sel_n    (sel_n),
        .last_pos (last_sel),
        .pos_q    (pos_q),
        .end_q    (end_q)
    );

    cfg_out_stage #(.DEPTH(DEPTH), .CHAIN_ACT_HIGH(CHAIN_ACT_HIGH)) u_out (
        .par_mode  (par_mode),
        .sel_n     (sel_n),
        .en_rst_n  (en_rst_n),
        .pos_q     (pos_q),
        .end_q     (end_q),
        .rd_byte   (rd_byte),
        .rd_addr   (rd_addr),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .chain_sel (chain_sel)
    );
endmodule

// File: rtl/cfg_stream_reader_chk.sv
// Module: property checker for the configuration bitstream reader, bound to
// every instance of the top module.
module cfg_stream_reader_chk #(
    parameter int CNT_W          = 9,
    parameter bit CHAIN_ACT_HIGH = 1'b0
) (
    input logic             clk,
    input logic             sel_n,
    input logic             en_rst_n,
    input logic             par_mode,
    input logic [CNT_W-1:0] pos_q,
    input logic             end_q,
    input logic [CNT_W-1:0] last_sel,
    input logic [7:0]       dout,
    input logic [7:0]       dout_oe,
    input logic             chain_sel
);
    localparam logic IDLE_LVL = !CHAIN_ACT_HIGH;

    // R1: a qualifying edge below the last position advances by one
    p_step_one_r1: assert property (@(posedge clk) disable iff (!en_rst_n)
        (!sel_n && !end_q && pos_q != last_sel) |=> pos_q == $past(pos_q) + 1'b1);

    // R2: reset returns the position to word 0
    p_rst_pos_r2: assert property (@(posedge clk)
        !en_rst_n |=> (pos_q == '0 && !end_q));

    // R2: lanes released while reset is held
    p_rst_lanes_r2: assert property (@(posedge clk)
        !en_rst_n |-> dout_oe == 8'h00);

    // R3: standby holds the position and releases the lanes
    p_standby_hold_r3: assert property (@(posedge clk) disable iff (!en_rst_n)
        sel_n |=> $stable(pos_q));

    p_standby_lanes_r3: assert property (@(posedge clk)
        sel_n |-> dout_oe == 8'h00);

    // R4: serial mode uses lane 0 only
    p_serial_lane_r4: assert property (@(posedge clk) disable iff (!en_rst_n)
        !par_mode |-> (dout_oe[7:1] == 7'h00 && dout[7:1] == 7'h00));

    // R6: past the end the position is frozen and lanes are released
    p_end_freeze_r6: assert property (@(posedge clk) disable iff (!en_rst_n)
        end_q |=> (end_q && $stable(pos_q)));

    p_end_lanes_r6: assert property (@(posedge clk) disable iff (!en_rst_n)
        end_q |-> dout_oe == 8'h00);

    // R7: before the end the chain select stays idle
    p_chain_idle_r7: assert property (@(posedge clk) disable iff (!en_rst_n)
        !end_q |-> chain_sel == IDLE_LVL);

    // R8: chain select idle while reset is held
    p_chain_rst_r8: assert property (@(posedge clk)
        !en_rst_n |-> chain_sel == IDLE_LVL);
endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(
    .CNT_W          (CNT_W),
    .CHAIN_ACT_HIGH (CHAIN_ACT_HIGH)
) u_chk (
    .clk       (clk),
    .sel_n     (sel_n),
    .en_rst_n  (en_rst_n),
    .par_mode  (par_mode),
    .pos_q     (pos_q),
    .end_q     (end_q),
    .last_sel  (last_sel),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .chain_sel (chain_sel)
);

// File: tb/cfg_stream_reader_tb.sv
module cfg_stream_reader_tb;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 4;
    localparam int AW     = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          sel_n = 1'b1;
    logic          en_rst_n = 1'b0;
    logic          par_mode = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    dout, dout_oe, dout_h, dout_oe_h;
    logic          chain_lo, chain_hi;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] img [DEPTH] = '{8'hA5, 8'h3C, 8'hF0, 8'h81};

    always #(CLK_NS / 2) clk = ~clk;

    cfg_stream_reader #(.DEPTH(DEPTH), .CHAIN_ACT_HIGH(1'b0)) u_dut (
        .clk(clk), .sel_n(sel_n), .en_rst_n(en_rst_n), .par_mode(par_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(dout), .dout_oe(dout_oe), .chain_sel(chain_lo));

    cfg_stream_reader #(.DEPTH(DEPTH), .CHAIN_ACT_HIGH(1'b1)) u_dut_hi (
        .clk(clk), .sel_n(sel_n), .en_rst_n(en_rst_n), .par_mode(par_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(dout_h), .dout_oe(dout_oe_h), .chain_sel(chain_hi));

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one edge, leaving time 1 ns after it for driving inputs.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset(input logic mode);
        tick();
        en_rst_n = 1'b0;
        sel_n    = 1'b0;
        par_mode = mode;
        settle();
        chk(dout_oe, 8'h00, "R2 lanes off in reset");
        chk({7'h0, chain_lo}, 8'h01, "R8 chain idle in reset (low pol)");
        tick();
        en_rst_n = 1'b1;
        settle();
    endtask

    task automatic t_preload();
        for (int i = 0; i < DEPTH; i++) begin
            tick();
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = img[i];
        end
        tick();
        wr_en = 1'b0;
    endtask

    task automatic t_parallel();
        do_reset(1'b1);
        for (int i = 0; i < DEPTH; i++) begin
            chk(dout_oe, 8'hFF, "R5 all lanes on");
            chk(dout, img[i], "R5/R10 byte value, R1 step");
            tick();
        end
        chk(dout_oe, 8'h00, "R6 lanes off past end");
        chk({7'h0, chain_lo}, 8'h00, "R7 chain active (low pol)");
        chk({7'h0, chain_hi}, 8'h01, "R9 chain active (high pol)");
        tick();
        chk(dout_oe, 8'h00, "R6 stays past end");
        sel_n = 1'b1;
        settle();
        chk({7'h0, chain_lo}, 8'h01, "R7 chain follows sel_n high");
        chk({7'h0, chain_hi}, 8'h00, "R9 idle level high pol");
        sel_n = 1'b0;
        settle();
        chk({7'h0, chain_lo}, 8'h00, "R7 chain follows sel_n low");
        en_rst_n = 1'b0;
        settle();
        chk({7'h0, chain_lo}, 8'h01, "R8 chain idle at reset");
        chk(dout_oe, 8'h00, "R2 lanes off at reset");
        tick();
        en_rst_n = 1'b1;
        settle();
        chk({7'h0, chain_lo}, 8'h01, "R8 chain idle after release");
        chk(dout_oe, 8'hFF, "R2 lanes on after release");
        chk(dout, img[0], "R2 position back to 0");
    endtask

    task automatic t_standby();
        do_reset(1'b1);
        tick();
        sel_n = 1'b1;
        settle();
        chk(dout_oe, 8'h00, "R3 lanes off in standby");
        tick(); tick(); tick();
        sel_n = 1'b0;
        settle();
        chk(dout, img[1], "R3 position held in standby");
        tick();
        chk(dout, img[2], "R1 advance after standby");
    endtask

    task automatic t_serial();
        do_reset(1'b0);
        for (int i = 0; i < DEPTH * 8; i++) begin
            chk(dout_oe, 8'h01, "R4 lane 0 only");
            chk(dout, {7'h0, img[i / 8][7 - (i % 8)]}, "R4 msb-first bit");
            tick();
        end
        chk(dout_oe, 8'h00, "R6 serial end");
        chk({7'h0, chain_hi}, 8'h01, "R7 chain active after serial end");
    endtask

    initial begin
        t_preload();
        t_parallel();
        t_standby();
        t_serial();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule